// File: doc/BRIEF.md
# I2C Register-Access Transaction Monitor

This block watches a stream of I2C bus events that an upstream bit-level decoder has already recovered: start, repeated start, stop, address-write, address-read, data-write and data-read, each with its byte. It follows only transactions aimed at one fixed 7-bit device address, which defaults to 0x68. It keeps its own mirror of that device's 64-byte register space. A transaction first sets the register pointer with a write. It then either writes data bytes, or issues a repeated start and reads data bytes back. Every byte seen in either direction is copied into the mirror at the pointer, and the pointer then advances.

A transaction that ends with stop raises a one-cycle completion pulse. The pulse says whether the transaction was a write session or a read session. It also presents a snapshot of the seven time registers, indices 0 to 6. Index 7 is the control byte and indices 0x08 to 0x3F are general-purpose RAM. These are mirrored like any other byte.

An address event that names another device raises a one-cycle flag, and the monitor goes idle. Any event that does not fit the current step of the transaction also sends the monitor back to idle, with no completion. A combinational read port exposes any mirrored byte.

Top module: `i2c_regmon`

## Requirements
- R1: After reset the following are all zero: `done_o`, `done_rd_o`, `foreign_o`, `time_o`, and every mirrored byte read through `rd_data_o`.
- R2: Event codes on `evt_kind_i` are: 0 start, 1 repeated start, 2 stop, 3 address-write, 4 address-read, 5 data-write, 6 data-read. In idle, only a start event is acted on. After it, an address-write event whose `evt_byte_i[6:0]` equals the device address is accepted. Bit 7 of the byte is ignored.
- R3: An address-write event that is expected but carries another address raises `foreign_o` for one cycle, in the cycle after the event. So does an address-read event that is expected but carries another address. The monitor returns to idle, stores nothing more, and gives no completion.
- R4: The first data-write event after an accepted address loads the pointer from `evt_byte_i[5:0]`. Bits 7:6 are ignored.
- R5: In the write-data step, each data-write byte is stored at the pointer, and the pointer then increments.
- R6: After a byte is stored at index 0x3F, the pointer wraps to 0x00.
- R7: A stop event in the write-data step raises `done_o` for exactly one cycle, in the cycle after the stop event. `done_rd_o` is 0 in that cycle. `time_o[8*i+7:8*i]` holds mirrored byte i, for i from 0 to 6.
- R8: A repeated start in the write-data step, followed by an address-read event to the device address, enters read mode. In read mode each data-read byte is stored at the pointer with the same increment.
- R9: A stop event in read mode raises `done_o` for one cycle with `done_rd_o` = 1 and the time snapshot.
- R10: An event that is not expected in the current step returns the monitor to idle, with no completion pulse. Data events that follow are not stored.
- R11: `time_o` and `done_rd_o` keep their values until the next completion pulse.
- R12: `rd_data_o` shows, combinationally, the mirrored byte at index `rd_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | An event is presented this cycle |
| evt_kind_i | input | 3 | Event code |
| evt_byte_i | input | 8 | Address or data byte of the event |
| rd_addr_i | input | 6 | Mirror read index |
| rd_data_o | output | 8 | Mirrored byte at `rd_addr_i` |
| done_o | output | 1 | One-cycle completion pulse |
| done_rd_o | output | 1 | 1 = last completion was a read session |
| time_o | output | 56 | Snapshot of time registers 0..6, byte i at bits 8i+7:8i |
| foreign_o | output | 1 | One-cycle pulse: another device was addressed |

## Verification
The assertions rely on two things about the inputs. The event inputs carry known values once reset is released. Each event is a single cycle of `evt_valid_i`, so a stop never shares a cycle with a stored byte. The stimulus respects this: every event is driven for one cycle and followed by an idle cycle. The only codes used are the seven defined ones, together with event kinds that are defined but out of place, which exercise the unexpected-event path. The read index is changed only between events, so mirror checks never race a write.

// File: rtl/i2c_regmon_pkg.sv
package i2c_regmon_pkg;
  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RESTART = 3'd1,
    EV_STOP    = 3'd2,
    EV_ADDR_WR = 3'd3,
    EV_ADDR_RD = 3'd4,
    EV_DATA_WR = 3'd5,
    EV_DATA_RD = 3'd6,
    EV_NONE    = 3'd7
  } evt_kind_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_DEV   = 3'd1,
    S_PTR   = 3'd2,
    S_WDATA = 3'd3,
    S_RDEV  = 3'd4,
    S_RDATA = 3'd5
  } mon_state_e;
endpackage

// File: rtl/i2c_regmon_fsm.sv
module i2c_regmon_fsm
  import i2c_regmon_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int unsigned PTR_W   = 6,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [2:0]        evt_kind_i,
  input  logic [DATA_W-1:0] evt_byte_i,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              end_req_o,
  output logic              end_rd_o,
  output logic              foreign_o
);
  mon_state_e       state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             foreign_q, foreign_d;
  evt_kind_e        kind;
  logic             addr_hit;

  assign kind     = evt_kind_e'(evt_kind_i);
  assign addr_hit = (evt_byte_i[6:0] == DEV_ADDR);

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    wr_en_o   = 1'b0;
    end_req_o = 1'b0;
    end_rd_o  = 1'b0;
    foreign_d = 1'b0;
    if (evt_valid_i) begin
      unique case (state_q)
        S_IDLE: if (kind == EV_START) state_d = S_DEV;
        S_DEV: begin
          if (kind == EV_ADDR_WR && addr_hit) state_d = S_PTR;
          else begin
            state_d   = S_IDLE;
            foreign_d = (kind == EV_ADDR_WR);
          end
        end
        S_PTR: begin
          if (kind == EV_DATA_WR) begin
            ptr_d   = evt_byte_i[PTR_W-1:0];
            state_d = S_WDATA;
          end else state_d = S_IDLE;
        end
        S_WDATA: begin
          unique case (kind)
            EV_DATA_WR: begin
              wr_en_o = 1'b1;
              ptr_d   = ptr_q + 1'b1;  // natural wrap at top of space
            end
            EV_STOP: begin
              end_req_o = 1'b1;
              state_d   = S_IDLE;
            end
            EV_RESTART: state_d = S_RDEV;
            default:    state_d = S_IDLE;
          endcase
        end
        S_RDEV: begin
          if (kind == EV_ADDR_RD && addr_hit) state_d = S_RDATA;
          else begin
            state_d   = S_IDLE;
            foreign_d = (kind == EV_ADDR_RD);
          end
        end
        S_RDATA: begin
          unique case (kind)
            EV_DATA_RD: begin
              wr_en_o = 1'b1;
              ptr_d   = ptr_q + 1'b1;
            end
            EV_STOP: begin
              end_req_o = 1'b1;
              end_rd_o  = 1'b1;
              state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
          endcase
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      ptr_q     <= '0;
      foreign_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      ptr_q     <= ptr_d;
      foreign_q <= foreign_d;
    end
  end

  assign wr_ptr_o  = ptr_q;
  assign wr_data_o = evt_byte_i;
  assign foreign_o = foreign_q;

  a_r2_idle_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !(evt_valid_i && evt_kind_i == EV_START)) |=> state_q == S_IDLE);

  a_r3_foreign_goes_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    foreign_q |-> state_q == S_IDLE);

  a_r6_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));

  a_r10_start_midway_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_kind_i == EV_START && state_q != S_IDLE) |=> state_q == S_IDLE);
endmodule

// File: rtl/i2c_regmon_regs.sv
module i2c_regmon_regs #(
  parameter int unsigned PTR_W    = 6,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_TIME = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [PTR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [PTR_W-1:0]           rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [NUM_TIME*DATA_W-1:0] live_time_o
);
  localparam int unsigned DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  for (genvar g = 0; g < NUM_TIME; g++) begin : g_time
    assign live_time_o[g*DATA_W +: DATA_W] = mem_q[g];
  end

  a_r5_byte_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/i2c_regmon_snap.sv
module i2c_regmon_snap #(
  parameter int unsigned W = 56
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         end_req_i,
  input  logic         end_rd_i,
  input  logic [W-1:0] live_time_i,
  output logic         done_o,
  output logic         done_rd_o,
  output logic [W-1:0] time_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      done_rd_o <= 1'b0;
      time_o    <= '0;
    end else begin
      done_o <= end_req_i;
      if (end_req_i) begin
        done_rd_o <= end_rd_i;
        time_o    <= live_time_i;
      end
    end
  end

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_snapshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_req_i |=> ($stable(time_o) && $stable(done_rd_o)));
endmodule

// File: rtl/i2c_regmon.sv
module i2c_regmon
  import i2c_regmon_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h68,
  parameter int unsigned PTR_W    = 6,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_TIME = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       evt_valid_i,
  input  logic [2:0]                 evt_kind_i,
  input  logic [DATA_W-1:0]          evt_byte_i,
  input  logic [PTR_W-1:0]           rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic                       done_o,
  output logic                       done_rd_o,
  output logic [NUM_TIME*DATA_W-1:0] time_o,
  output logic                       foreign_o
);
  localparam int unsigned TIME_W = NUM_TIME * DATA_W;

  logic              wr_en, end_req, end_rd;
  logic [PTR_W-1:0]  wr_ptr;
  logic [DATA_W-1:0] wr_data;
  logic [TIME_W-1:0] live_time;

  i2c_regmon_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .evt_valid_i, .evt_kind_i, .evt_byte_i,
    .wr_en_o(wr_en), .wr_ptr_o(wr_ptr), .wr_data_o(wr_data),
    .end_req_o(end_req), .end_rd_o(end_rd), .foreign_o(foreign_o)
  );

  i2c_regmon_regs #(.PTR_W(PTR_W), .DATA_W(DATA_W), .NUM_TIME(NUM_TIME)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_ptr), .wr_data_i(wr_data),
    .rd_addr_i, .rd_data_o, .live_time_o(live_time)
  );

  i2c_regmon_snap #(.W(TIME_W)) u_snap (
    .clk_i, .rst_ni, .end_req_i(end_req), .end_rd_i(end_rd),
    .live_time_i(live_time), .done_o, .done_rd_o, .time_o
  );

  a_r3_no_done_with_foreign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && foreign_o));
endmodule

// File: tb/i2c_regmon_bench.sv
`timescale 1ns/1ps
module i2c_regmon_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_kind = '0;
  logic [7:0]  evt_byte = '0;
  logic [5:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        done, done_rd, foreign;
  logic [55:0] time_v;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  i2c_regmon u_i2c_regmon (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_kind_i(evt_kind),
    .evt_byte_i(evt_byte), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .done_o(done), .done_rd_o(done_rd), .time_o(time_v), .foreign_o(foreign)
  );

  localparam logic [2:0] K_ST = 3'd0, K_RS = 3'd1, K_SP = 3'd2, K_AW = 3'd3,
                         K_AR = 3'd4, K_DW = 3'd5, K_DR = 3'd6;

  // {kind, byte, exp_done, exp_rd, exp_foreign}
  localparam int NV = 21;
  localparam logic [13:0] VEC [NV] = '{
    {K_ST, 8'h00, 3'b000}, {K_AW, 8'h68, 3'b000}, {K_DW, 8'h00, 3'b000},
    {K_DW, 8'h11, 3'b000}, {K_DW, 8'h22, 3'b000}, {K_DW, 8'h33, 3'b000},
    {K_DW, 8'h44, 3'b000}, {K_DW, 8'h55, 3'b000}, {K_DW, 8'h66, 3'b000},
    {K_DW, 8'h77, 3'b000}, {K_SP, 8'h00, 3'b100},
    {K_ST, 8'h00, 3'b000}, {K_AW, 8'h50, 3'b001},
    {K_ST, 8'h00, 3'b000}, {K_AW, 8'h68, 3'b000}, {K_DW, 8'h02, 3'b000},
    {K_RS, 8'h00, 3'b000}, {K_AR, 8'h68, 3'b000}, {K_DR, 8'hA1, 3'b000},
    {K_DR, 8'hA2, 3'b000}, {K_SP, 8'h00, 3'b110}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // event visible one edge later; outputs sampled at the following negedge
  task automatic send(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = k; evt_byte = b;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, input logic [7:0] exp, input string req);
    rd_addr = a;
    #1;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [55:0] t_exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 0 && foreign == 0 && done_rd == 0, "R1 flags", {done, done_rd, foreign}, 0);
    chk(time_v == 0, "R1 time", time_v, 0);
    peek(6'h00, 8'h00, "R1 mem0");
    peek(6'h3F, 8'h00, "R1 mem3f");
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk: R5 R7 R3 R8 R9
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][13:11], VEC[i][10:3]);
      chk(done == VEC[i][2], $sformatf("R7 R9 done row %0d", i), done, VEC[i][2]);
      chk(foreign == VEC[i][0], $sformatf("R3 foreign row %0d", i), foreign, VEC[i][0]);
      if (VEC[i][2]) chk(done_rd == VEC[i][1], $sformatf("R9 rd row %0d", i), done_rd, VEC[i][1]);
    end
    t_exp = {8'h77, 8'h66, 8'h55, 8'hA2, 8'hA1, 8'h22, 8'h11};
    chk(time_v == t_exp, "R8 R9 time snapshot", time_v, t_exp);
    @(negedge clk);
    chk(done == 0, "R7 single pulse", done, 0);
    peek(6'h02, 8'hA1, "R8 read byte stored");
    peek(6'h07, 8'h00, "R12 control untouched");
    peek(6'h03, 8'hA2, "R12 mirror read");

    // R6 wrap
    send(K_ST, 0); send(K_AW, 8'h68); send(K_DW, 8'h3E);
    send(K_DW, 8'hC1); send(K_DW, 8'hC2); send(K_DW, 8'hC3); send(K_SP, 0);
    chk(done && !done_rd, "R7 write completion", {done, done_rd}, 2'b10);
    peek(6'h3E, 8'hC1, "R6 at 3e");
    peek(6'h3F, 8'hC2, "R6 at 3f");
    peek(6'h00, 8'hC3, "R6 wrapped to 0");
    t_exp[7:0] = 8'hC3;
    chk(time_v == t_exp, "R7 time after wrap", time_v, t_exp);

    // R4 pointer upper bits ignored, R2 address bit 7 ignored
    send(K_ST, 0); send(K_AW, 8'hE8); send(K_DW, 8'hC8); send(K_DW, 8'h5A); send(K_SP, 0);
    chk(done == 1, "R2 addr bit7 ignored", done, 1);
    peek(6'h08, 8'h5A, "R4 pointer masked");

    // R10 unexpected event
    send(K_ST, 0); send(K_AW, 8'h68); send(K_DW, 8'h10); send(K_DR, 8'h99);
    chk(done == 0, "R10 no done on abort", done, 0);
    send(K_DW, 8'h55); send(K_SP, 0);
    chk(done == 0, "R10 stop after abort", done, 0);
    peek(6'h10, 8'h00, "R10 nothing stored");
    chk(time_v == t_exp && done_rd == 0, "R11 snapshot held", time_v, t_exp);

    // R3 foreign in read phase
    send(K_ST, 0); send(K_AW, 8'h68); send(K_DW, 8'h20); send(K_RS, 0); send(K_AR, 8'h51);
    chk(foreign == 1, "R3 foreign read addr", foreign, 1);
    send(K_DR, 8'h77); send(K_SP, 0);
    chk(done == 0 && foreign == 0, "R3 no completion", {done, foreign}, 0);
    peek(6'h20, 8'h00, "R3 nothing stored");

    // R2 address without start is ignored
    send(K_AW, 8'h68); send(K_DW, 8'h30); send(K_DW, 8'h44); send(K_SP, 0);
    chk(done == 0, "R2 no start no done", done, 0);
    peek(6'h30, 8'h00, "R2 no store without start");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule